// File: doc/BRIEF.md
# ADC Scan Conversion Sequencer

This block is the digital scheduler that sits in front of a bank of analog-to-digital converters. A channel mask names the channels that belong to the scan, and a 5-bit source selector picks the one trigger that starts every scan. When that trigger fires, the sequencer launches all member channels. Channels that own a dedicated converter are started together. Channels that use the common converter are started one at a time, lowest index first. Each start is a pulse that carries a channel index, and the converter answers with a done pulse and a 12-bit result.

Channels fall into three classes, set by index. The lowest `NUM_DED` channels each own a converter. The next `NUM_C2` channels use the common converter. Every channel above those also uses the common converter and can only be converted by a scan. A channel from either of the two lower classes joins the scan only if its own 5-bit trigger field holds the scan code. Every result is held in a per-channel register with a data-ready flag. Software polls the flag, then reads the result through a read port, and the read clears the flag.

A trigger that arrives while a scan is still running is dropped, and this sets a sticky overrun flag. The converters themselves are outside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: `scanSel` picks the scan trigger. Code 1 takes the one-cycle `swTrig` strobe. Code 4+k takes external line `extTrig[k]`. Code 0, and any code with no source behind it, never starts a scan.
- R2: When `extLevel[k]`=0, line k triggers only on a rising edge, so a line held high starts exactly one scan. When `extLevel[k]`=1, the line triggers on every cycle it is high.
- R3: Member channels on the common converter are started in strictly ascending index order, lowest index first. `shStart` carries the index on `shChan`, and the first start comes one cycle after the trigger cycle.
- R4: At most one conversion on the common converter is outstanding at a time. The next `shStart` comes no earlier than the cycle after `shDone`.
- R5: All member dedicated channels (indices 0..NUM_DED-1) get their `dedStart` bit in the same single cycle, one cycle after the trigger cycle.
- R6: A channel with index below NUM_DED+NUM_C2 is a member only if its mask bit is set and its field `chanTrig[5*ch +: 5]` equals 2, the scan code. Otherwise it gets no start and its ready flag does not rise.
- R7: A channel with index NUM_DED+NUM_C2 or above is a member whenever its mask bit is set, and it is always converted on the common converter.
- R8: A result is written to its channel's register, and `dataReady[ch]` is set, on the clock edge that samples the matching done pulse. `rdData` shows the result of the channel on `rdChan` combinationally.
- R9: A read (`rdEn` with `rdChan`=ch) clears `dataReady[ch]` at the next edge. If a result for the same channel is stored on that same edge, the flag ends up set.
- R10: A trigger that arrives while `scanBusy` is high starts nothing and sets `overrun`, which stays high until reset.
- R11: After reset, `dataReady`, `scanBusy`, `overrun`, `shStart` and `dedStart` are all zero.
- R12: `scanBusy` rises one cycle after a trigger that has at least one member. It falls on the edge that stores the last result of the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scanSel | input | 5 | Scan trigger source code |
| swTrig | input | 1 | Software trigger strobe |
| extTrig | input | 4 | External trigger lines |
| extLevel | input | 4 | Per-line sensitivity: 0 rising edge, 1 high level |
| scanMask | input | 8 | Scan membership mask, one bit per channel |
| chanTrig | input | 20 | Trigger field per channel for channels 0..3, 5 bits each |
| dedStart | output | 2 | Start pulses to the dedicated converters |
| dedDone | input | 2 | Done pulses from the dedicated converters |
| dedResult | input | 24 | Dedicated converter results, 12 bits each |
| shStart | output | 1 | Start pulse to the common converter |
| shChan | output | 3 | Channel index sent with `shStart` |
| shDone | input | 1 | Done pulse from the common converter |
| shResult | input | 12 | Common converter result |
| rdEn | input | 1 | Result read strobe |
| rdChan | input | 3 | Channel being read |
| rdData | output | 12 | Result of the channel on `rdChan` |
| dataReady | output | 8 | Per-channel result-ready flags |
| scanBusy | output | 1 | Scan in progress |
| overrun | output | 1 | Sticky flag: a trigger was dropped during a scan |

## Verification
Two events can land on the same clock edge: a software read that clears a channel's ready flag, and a converter done that stores a new result for that same channel. The bench holds a read of channel 7 active through a whole scan in which channel 7 is the only member. On the cycle where the done pulse is visible, it checks that the flag is still low. One cycle later, it checks that the flag is high and that the new value is on the read port. A second same-cycle case comes from a trigger strobe issued during a running scan. The bench judges it by the count of scans that start and by the overrun flag.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Width of every trigger-source code field.
  localparam int SEL_W = 5;

  // Trigger-source code values.
  localparam int SRC_SW       = 1;  // software strobe
  localparam int SRC_SCAN     = 2;  // "follow the scan" (per-channel field only)
  localparam int SRC_EXT_BASE = 4;  // external line k is code SRC_EXT_BASE + k

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } seqState_t;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic shIssue;  // a common-converter start goes out this cycle
    logic shStore;  // the common-converter result is captured this cycle
  } seqStrobe_t;

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig
  import adc_scan_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   scanSel,
  input  logic               swTrig,
  input  logic [NUM_EXT-1:0] extTrig,
  input  logic [NUM_EXT-1:0] extLevel,
  output logic               trigEvt
);

  logic [NUM_EXT-1:0] prevQ;
  logic [NUM_EXT-1:0] lineEvt;

  // Previous line values, kept for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= '0;
    else        prevQ <= extTrig;
  end

  // Each line is either edge- or level-sensitive.
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
    assign lineEvt[k] = extLevel[k] ? extTrig[k] : (extTrig[k] & ~prevQ[k]);
  end

  // Source selection. Unused codes yield no event.
  always_comb begin
    trigEvt = 1'b0;
    if (scanSel == SEL_W'(SRC_SW)) trigEvt = swTrig;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (scanSel == SEL_W'(SRC_EXT_BASE + k)) trigEvt = lineEvt[k];
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_DED = 2,
  parameter int NUM_C2  = 2,
  parameter int IDX_W   = $clog2(NUM_CH)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            trigEvt,
  input  logic [NUM_CH-1:0]               scanMask,
  input  logic [(NUM_DED+NUM_C2)*SEL_W-1:0] chanTrig,
  input  logic [NUM_DED-1:0]              dedDone,
  input  logic                            shDone,
  output logic [NUM_DED-1:0]              dedStart,
  output logic [NUM_DED-1:0]              dedAccept,
  output logic                            shStart,
  output logic [IDX_W-1:0]                shChan,
  output seqStrobe_t                      strb,
  output logic                            scanBusy,
  output logic                            overrun
);

  localparam int NUM_TRIGGED = NUM_DED + NUM_C2;
  localparam logic [NUM_CH-1:0] DED_MASK = NUM_CH'((1 << NUM_DED) - 1);

  seqState_t           state;
  logic [NUM_CH-1:0]   elig;
  logic [NUM_CH-1:0]   eligSh;
  logic [NUM_DED-1:0]  eligDed;
  logic [NUM_DED-1:0]  dedPend, dedPendN;
  logic [NUM_CH-1:0]   shPend, shPendN;
  logic                waitSh, waitShN;
  logic [NUM_DED-1:0]  dedStartQ;
  logic                ovrQ;
  logic [IDX_W-1:0]    pickIdx;
  logic [NUM_CH-1:0]   pickMask;
  logic                issue, store, running;

  // Scan membership, one entry per channel class.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_elig
    if (ch < NUM_TRIGGED) begin : g_trigged
      assign elig[ch] = scanMask[ch] &&
                        (chanTrig[ch*SEL_W +: SEL_W] == SEL_W'(SRC_SCAN));
    end else begin : g_scanonly
      assign elig[ch] = scanMask[ch];
    end
  end

  assign eligDed = elig[NUM_DED-1:0];
  assign eligSh  = elig & ~DED_MASK;

  // Lowest pending common-converter channel wins.
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (shPend[i]) pickIdx = IDX_W'(i);
    end
  end
  assign pickMask = NUM_CH'(1) << pickIdx;

  assign running   = (state == ST_RUN);
  assign issue     = running && !waitSh && (|shPend);
  assign store     = running && waitSh && shDone;
  assign dedAccept = running ? (dedDone & dedPend) : '0;

  assign dedPendN = dedPend & ~dedAccept;
  assign shPendN  = issue ? (shPend & ~pickMask) : shPend;
  assign waitShN  = issue ? 1'b1 : (store ? 1'b0 : waitSh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dedPend   <= '0;
      shPend    <= '0;
      waitSh    <= 1'b0;
      dedStartQ <= '0;
      ovrQ      <= 1'b0;
    end else begin
      dedStartQ <= '0;
      if (!running) begin
        if (trigEvt && (|elig)) begin
          state     <= ST_RUN;
          dedPend   <= eligDed;
          shPend    <= eligSh;
          dedStartQ <= eligDed;
          waitSh    <= 1'b0;
        end
      end else begin
        if (trigEvt) ovrQ <= 1'b1;
        dedPend <= dedPendN;
        shPend  <= shPendN;
        waitSh  <= waitShN;
        if ((dedPendN == '0) && (shPendN == '0) && !waitShN) state <= ST_IDLE;
      end
    end
  end

  assign dedStart     = dedStartQ;
  assign shStart      = issue;
  assign shChan       = pickIdx;
  assign strb.shIssue = issue;
  assign strb.shStore = store;
  assign scanBusy     = running;
  assign overrun      = ovrQ;

endmodule

// File: rtl/adc_scan_dpath.sv
module adc_scan_dpath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_DED = 2,
  parameter int RES_W   = 12,
  parameter int IDX_W   = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seqStrobe_t               strb,
  input  logic [IDX_W-1:0]         issueChan,
  input  logic [RES_W-1:0]         shResult,
  input  logic [NUM_DED-1:0]       dedAccept,
  input  logic [NUM_DED*RES_W-1:0] dedResult,
  input  logic                     rdEn,
  input  logic [IDX_W-1:0]         rdChan,
  output logic [RES_W-1:0]         rdData,
  output logic [NUM_CH-1:0]        dataReady
);

  logic [IDX_W-1:0] curChan;
  logic [RES_W-1:0] resArr [NUM_CH];

  // Channel now converting on the common core.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            curChan <= '0;
    else if (strb.shIssue) curChan <= issueChan;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic             setSh;
    logic             setDed;
    logic [RES_W-1:0] dedVal;
    logic [RES_W-1:0] resQ;
    logic             rdyQ;

    assign setSh = strb.shStore && (curChan == IDX_W'(ch));

    if (ch < NUM_DED) begin : g_ded
      assign setDed = dedAccept[ch];
      assign dedVal = dedResult[ch*RES_W +: RES_W];
    end else begin : g_shr
      assign setDed = 1'b0;
      assign dedVal = '0;
    end

    // A store on the same edge as a read leaves the flag set.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        resQ <= '0;
        rdyQ <= 1'b0;
      end else begin
        if (setDed)     resQ <= dedVal;
        else if (setSh) resQ <= shResult;
        if (setDed || setSh)                       rdyQ <= 1'b1;
        else if (rdEn && (rdChan == IDX_W'(ch)))   rdyQ <= 1'b0;
      end
    end

    assign resArr[ch]    = resQ;
    assign dataReady[ch] = rdyQ;
  end

  assign rdData = resArr[rdChan];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_DED = 2,
  parameter int NUM_C2  = 2,
  parameter int NUM_EXT = 4,
  parameter int RES_W   = 12,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SEL_W-1:0]                  scanSel,
  input  logic                              swTrig,
  input  logic [NUM_EXT-1:0]                extTrig,
  input  logic [NUM_EXT-1:0]                extLevel,
  input  logic [NUM_CH-1:0]                 scanMask,
  input  logic [(NUM_DED+NUM_C2)*SEL_W-1:0] chanTrig,
  output logic [NUM_DED-1:0]                dedStart,
  input  logic [NUM_DED-1:0]                dedDone,
  input  logic [NUM_DED*RES_W-1:0]          dedResult,
  output logic                              shStart,
  output logic [IDX_W-1:0]                  shChan,
  input  logic                              shDone,
  input  logic [RES_W-1:0]                  shResult,
  input  logic                              rdEn,
  input  logic [IDX_W-1:0]                  rdChan,
  output logic [RES_W-1:0]                  rdData,
  output logic [NUM_CH-1:0]                 dataReady,
  output logic                              scanBusy,
  output logic                              overrun
);

  logic               trigEvt;
  seqStrobe_t         strb;
  logic [NUM_DED-1:0] dedAccept;

  adc_scan_trig #(.NUM_EXT(NUM_EXT)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .scanSel  (scanSel),
    .swTrig   (swTrig),
    .extTrig  (extTrig),
    .extLevel (extLevel),
    .trigEvt  (trigEvt)
  );

  adc_scan_ctrl #(
    .NUM_CH  (NUM_CH),
    .NUM_DED (NUM_DED),
    .NUM_C2  (NUM_C2),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigEvt   (trigEvt),
    .scanMask  (scanMask),
    .chanTrig  (chanTrig),
    .dedDone   (dedDone),
    .shDone    (shDone),
    .dedStart  (dedStart),
    .dedAccept (dedAccept),
    .shStart   (shStart),
    .shChan    (shChan),
    .strb      (strb),
    .scanBusy  (scanBusy),
    .overrun   (overrun)
  );

  adc_scan_dpath #(
    .NUM_CH  (NUM_CH),
    .NUM_DED (NUM_DED),
    .RES_W   (RES_W),
    .IDX_W   (IDX_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .issueChan (shChan),
    .shResult  (shResult),
    .dedAccept (dedAccept),
    .dedResult (dedResult),
    .rdEn      (rdEn),
    .rdChan    (rdChan),
    .rdData    (rdData),
    .dataReady (dataReady)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_DED = 2,
  localparam int IDX_W  = $clog2(NUM_CH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shStart,
  input logic [IDX_W-1:0]   shChan,
  input logic               shDone,
  input logic [NUM_DED-1:0] dedStart,
  input logic [NUM_CH-1:0]  dataReady,
  input logic               scanBusy,
  input logic               overrun
);

  logic             outstanding;
  logic [IDX_W-1:0] lastChan;
  logic             firstInScan;

  // Shadow of the common-converter handshake, built from the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      lastChan    <= '0;
      firstInScan <= 1'b1;
    end else begin
      if (shStart) begin
        outstanding <= 1'b1;
        lastChan    <= shChan;
      end else if (shDone) begin
        outstanding <= 1'b0;
      end
      if (!scanBusy)    firstInScan <= 1'b1;
      else if (shStart) firstInScan <= 1'b0;
    end
  end

  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    shStart |-> !outstanding);

  a_r3_ascending_order: assert property (@(posedge clk) disable iff (!rst_n)
    (shStart && !firstInScan) |-> (shChan > lastChan));

  a_r12_starts_inside_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (shStart || (|dedStart)) |-> scanBusy);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (shDone && outstanding) |=> dataReady[lastChan]);

  a_r7_common_core_class: assert property (@(posedge clk) disable iff (!rst_n)
    shStart |-> (shChan >= IDX_W'(NUM_DED)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_DED (NUM_DED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shStart   (shStart),
  .shChan    (shChan),
  .shDone    (shDone),
  .dedStart  (dedStart),
  .dataReady (dataReady),
  .scanBusy  (scanBusy),
  .overrun   (overrun)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SH_LAT     = 3;
  localparam int DED_LAT    = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  scanSel = '0;
  logic        swTrig = 1'b0;
  logic [3:0]  extTrig = '0;
  logic [3:0]  extLevel = '0;
  logic [7:0]  scanMask = '0;
  logic [19:0] chanTrig = '0;
  logic [1:0]  dedStart;
  logic [1:0]  dedDone = '0;
  logic [23:0] dedResult = '0;
  logic        shStart;
  logic [2:0]  shChan;
  logic        shDone = 1'b0;
  logic [11:0] shResult = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdChan = '0;
  logic [11:0] rdData;
  logic [7:0]  dataReady;
  logic        scanBusy;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  int scans = 0;
  int shN = 0;
  int dedN = 0;
  int ordViol = 0;
  logic [1:0] dedLog = '0;
  logic [2:0] shLog [64];
  logic busyPrev = 1'b0;

  int shCnt = 0;
  logic [2:0] stubChan = '0;
  int dCnt [2] = '{0, 0};

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .scanSel(scanSel), .swTrig(swTrig),
    .extTrig(extTrig), .extLevel(extLevel), .scanMask(scanMask),
    .chanTrig(chanTrig), .dedStart(dedStart), .dedDone(dedDone),
    .dedResult(dedResult), .shStart(shStart), .shChan(shChan),
    .shDone(shDone), .shResult(shResult), .rdEn(rdEn), .rdChan(rdChan),
    .rdData(rdData), .dataReady(dataReady), .scanBusy(scanBusy),
    .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] expv(int ch, int s);
    return 12'((s * 16 + ch + 1) & 12'hFFF);
  endfunction

  // Behavioural common converter: done SH_LAT cycles after start.
  always @(posedge clk) begin
    shDone <= 1'b0;
    if (shCnt > 0) begin
      shCnt <= shCnt - 1;
      if (shCnt == 1) begin
        shDone   <= 1'b1;
        shResult <= expv(int'(stubChan), seed);
      end
    end
    if (shStart) begin
      shCnt    <= SH_LAT;
      stubChan <= shChan;
    end
  end

  // Behavioural dedicated converters.
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      dedDone[i] <= 1'b0;
      if (dCnt[i] > 0) begin
        dCnt[i] <= dCnt[i] - 1;
        if (dCnt[i] == 1) begin
          dedDone[i] <= 1'b1;
          dedResult[i*12 +: 12] <= expv(i, seed);
        end
      end
      if (dedStart[i]) dCnt[i] <= DED_LAT;
    end
  end

  // Observation away from the active edge.
  always @(negedge clk) begin
    if (scanBusy && !busyPrev) scans++;
    busyPrev = scanBusy;
    if (shStart) begin
      if (shN < 64) shLog[shN] = shChan;
      shN++;
      if (shCnt != 0) ordViol++;
    end
    if (|dedStart) begin
      dedLog = dedStart;
      dedN++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    shN = 0; dedN = 0; dedLog = '0; ordViol = 0;
  endtask

  task automatic swPulse();
    @(negedge clk) swTrig = 1'b1;
    @(negedge clk) swTrig = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && scanBusy; i++) @(negedge clk);
  endtask

  task automatic readCh(int ch, logic [11:0] exp);
    @(negedge clk);
    rdEn = 1'b1; rdChan = 3'(ch);
    #1;
    chk("R8 rdData", 32'(rdData), 32'(exp));
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 read clears ready", 32'(dataReady[ch]), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 dataReady", 32'(dataReady), 32'd0);
    chk("R11 scanBusy", 32'(scanBusy), 32'd0);
    chk("R11 overrun", 32'(overrun), 32'd0);
    chk("R11 starts", 32'({shStart, dedStart}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_full_scan();
    scanSel = 5'd1; scanMask = 8'hFF;
    chanTrig = {5'd2, 5'd2, 5'd2, 5'd2};
    seed = 1; clearLogs();
    swPulse();
    chk("R12 busy after trigger", 32'(scanBusy), 32'd1);
    chk("R5 dedicated start together", 32'(dedStart), 32'b11);
    chk("R3 first shared start", 32'({shStart, shChan}), 32'({1'b1, 3'd2}));
    waitIdle();
    chk("R12 last store with busy fall", 32'(dataReady), 32'hFF);
    chk("R3 shared count", 32'(shN), 32'd6);
    for (int i = 0; i < 6; i++) chk("R3 order", 32'(shLog[i]), 32'(i + 2));
    chk("R4 one outstanding", 32'(ordViol), 32'd0);
    chk("R5 dedicated start once", 32'(dedN), 32'd1);
    for (int ch = 0; ch < 8; ch++) readCh(ch, expv(ch, 1));
  endtask

  task automatic t_skip();
    scanSel = 5'd1; scanMask = 8'b1001_1011;
    chanTrig = {5'd5, 5'd2, 5'd2, 5'd0};
    seed = 2; clearLogs();
    swPulse();
    waitIdle();
    chk("R6 R7 membership ready", 32'(dataReady), 32'b1001_0010);
    chk("R6 dedicated subset", 32'(dedLog), 32'b10);
    chk("R7 shared count", 32'(shN), 32'd2);
    chk("R7 shared first", 32'(shLog[0]), 32'd4);
    chk("R7 shared second", 32'(shLog[1]), 32'd7);
    readCh(1, expv(1, 2));
    readCh(4, expv(4, 2));
    readCh(7, expv(7, 2));
  endtask

  task automatic t_trig_source();
    int s0;
    seed = 3;
    s0 = scans;
    scanSel = 5'd0;
    swPulse();
    repeat (4) @(negedge clk);
    chk("R1 code 0 no scan", 32'(scans), 32'(s0));
    scanSel = 5'd4; extLevel = 4'b0000;
    @(negedge clk) extTrig = 4'b0010;
    @(negedge clk) extTrig = 4'b0000;
    repeat (4) @(negedge clk);
    chk("R1 other line ignored", 32'(scans), 32'(s0));
    @(negedge clk) extTrig = 4'b0001;
    @(negedge clk);
    chk("R1 line 0 starts scan", 32'(scanBusy), 32'd1);
    waitIdle();
    repeat (10) @(negedge clk);
    chk("R2 held edge line one scan", 32'(scans), 32'(s0 + 1));
    extTrig = 4'b0000;
    scanSel = 5'd5; extLevel = 4'b0010;
    @(negedge clk) extTrig = 4'b0010;
    @(negedge clk) extTrig = 4'b0000;
    chk("R2 level line starts scan", 32'(scanBusy), 32'd1);
    waitIdle();
    chk("R2 level single scan", 32'(scans), 32'(s0 + 2));
    extLevel = 4'b0000;
  endtask

  task automatic t_overrun();
    int s0;
    seed = 4;
    scanSel = 5'd1;
    chk("R10 overrun clear before", 32'(overrun), 32'd0);
    s0 = scans;
    swPulse();
    swPulse();
    waitIdle();
    chk("R10 second trigger dropped", 32'(scans), 32'(s0 + 1));
    chk("R10 overrun set", 32'(overrun), 32'd1);
    swPulse();
    waitIdle();
    chk("R10 overrun sticky", 32'(overrun), 32'd1);
  endtask

  task automatic t_collide();
    seed = 5;
    scanSel = 5'd1; scanMask = 8'b1000_0000;
    @(negedge clk) begin rdEn = 1'b1; rdChan = 3'd7; end
    swPulse();
    for (int i = 0; i < 100 && !shDone; i++) @(negedge clk);
    chk("R9 held read kept flag low", 32'(dataReady[7]), 32'd0);
    @(negedge clk);
    chk("R9 store wins over read", 32'(dataReady[7]), 32'd1);
    chk("R9 value on collision", 32'(rdData), 32'(expv(7, 5)));
    rdEn = 1'b0;
    waitIdle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_scan();
    t_skip();
    t_trig_source();
    t_overrun();
    t_collide();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule